// File: doc/BRIEF.md
# Multiplexed GPIO Port Controller

An eight-pin general-purpose I/O port whose pins can each be lent to an alternate function belonging to the external bus or to a NAND flash interface. Four byte-wide registers hold the port state. An output latch gives the driven value. A direction register picks input or output. A function register picks plain port or alternate use. A standby drive register keeps chosen pin buffers alive while the chip is in standby. Writes are synchronous, byte-wide and addressed. Reads are combinational.

For each pin, the block combines the registers with strobe, address and status signals from a bus controller stub. From these it produces the pad output value and the output enable, and it routes pad levels back to the wait and ready/busy inputs of the bus side. On two pins the latch bit does a second job when the alternate function is enabled: it chooses which of two strobes leaves the pin. A mode input sets the reset value of pin 0's function bit, so the read strobe can be live straight out of reset.

Register addresses (reg_addr): 0 latch/data, 1 direction, 2 function, 3 standby drive.

Top module: `gpio_mux_port`

## Requirements
- R1: The direction register resets to 0x00. A plain pin drives pad_out from its latch bit with pad_oe = 1 when its direction bit is 1, and has pad_oe = 0 when the bit is 0.
- R2: The direction (address 1) and function (address 2) registers are write-only. A read of either address returns 0x00 whatever was written.
- R3: The latch resets to 0xFF. A read of address 0 returns the latch bit for output pins and the pad level for input pins.
- R4: When pin 2 has direction 1 and function 1, it drives nand_we_n if its latch bit is 0 and bus_wr_hi_n if its latch bit is 1, with pad_oe[2] = 1.
- R5: When pin 1 has direction 1 and function 1, it drives nand_re_n if its latch bit is 0 and bus_wr_lo_n if its latch bit is 1, with pad_oe[1] = 1.
- R6: When pin 1 or pin 2 has direction 0 and function 1, the pin behaves as a plain input: pad_oe = 0 and the pad level is read back at address 0.
- R7: When function bit 3 (or 4) is 1, pin 3 (or 4) drives bus_addr_hi[0] (or [1]) with output enabled. With the function bit at 0 the pin is a plain port pin.
- R8: When pin 6 has function 1 and direction 0, pad 6 is routed to bus_wait_n. When pin 5 has function 1, it routes pad 5 to nand_ready with direction 0, or drives bus_rw with direction 1. An input that is not routed reads as 1.
- R9: When function bit 0 is 1, pin 0 drives bus_rd_n with output enabled, whatever its direction bit. Function bit 0 resets to the value of boot_rd_func, and the other function bits reset to 0.
- R10: The standby drive register resets to 0xFF and reads back at address 3. While standby is 1, any pin whose drive bit is 0 has pad_oe = 0 and its internal input level forced to 1.
- R11: From reset, writing the latch with bits 1 and 2 at 0, then the function register, then the direction register, never puts a low level on pins 1 or 2 while the NAND strobes are idle high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_rd_func | input | 1 | Reset value of pin 0 function bit |
| standby | input | 1 | Standby mode indicator |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data |
| bus_rd_n | input | 1 | Read strobe from bus controller |
| bus_wr_lo_n | input | 1 | Lower-byte write strobe |
| bus_wr_hi_n | input | 1 | Upper-byte write strobe |
| bus_rw | input | 1 | Read/write indicator |
| bus_addr_hi | input | 2 | External address bits 24 and 25 |
| nand_re_n | input | 1 | NAND read-enable strobe |
| nand_we_n | input | 1 | NAND write-enable strobe |
| bus_wait_n | output | 1 | Wait input routed from pin 6 |
| nand_ready | output | 1 | Ready/busy routed from pin 5 |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |

## Verification
A register write takes effect at the clock edge that samples reg_wr. Pad outputs, routed inputs and read data follow combinationally from the registers and the stub inputs, so every result is due in the first cycle after the write edge and at once after a change to a stub or pad input. The bench drives inputs on the falling edge. It samples one nanosecond after a falling edge for combinational paths, and on the following falling edge for a write's result, so it never reads at a rising edge.

// File: rtl/gpio_pkg.sv
// Package: shared constants for the multiplexed GPIO port.
// Assumes an eight-pin port with fixed alternate-function pin positions.
package gpio_pkg;
    localparam int unsigned N_PINS   = 8;
    localparam int unsigned AW       = 2;

    typedef enum logic [AW-1:0] {
        REG_DATA  = 2'd0,
        REG_DIR   = 2'd1,
        REG_FUNC  = 2'd2,
        REG_DRIVE = 2'd3
    } reg_sel_e;

    // Alternate-function pin positions (behaviour depends on them)
    localparam int unsigned PIN_RD   = 0;
    localparam int unsigned PIN_RE   = 1;
    localparam int unsigned PIN_WE   = 2;
    localparam int unsigned PIN_A24  = 3;
    localparam int unsigned PIN_A25  = 4;
    localparam int unsigned PIN_RB   = 5;
    localparam int unsigned PIN_WAIT = 6;
endpackage

// File: rtl/gpio_regs.sv
// Module: gpio_regs
// Holds the latch, direction, function and standby drive registers and
// forms the read data. Assumes single-cycle writes and combinational reads.
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int unsigned W        = N_PINS,
    parameter logic [W-1:0] RD_FIXED = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          boot_rd_func,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_wr,
    input  logic [W-1:0]  reg_wdata,
    input  logic [W-1:0]  pin_lvl,
    output logic [W-1:0]  reg_rdata,
    output logic [W-1:0]  latch_q,
    output logic [W-1:0]  dir_q,
    output logic [W-1:0]  func_q,
    output logic [W-1:0]  drive_q
);
    localparam logic [W-1:0] ONES = '1;

    // Register update: synchronous reset, addressed byte writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= ONES;
            dir_q   <= '0;
            func_q  <= {{(W-1){1'b0}}, boot_rd_func};
            drive_q <= ONES;
        end else if (reg_wr) begin
            case (reg_sel_e'(reg_addr))
                REG_DATA:  latch_q <= reg_wdata;
                REG_DIR:   dir_q   <= reg_wdata;
                REG_FUNC:  func_q  <= reg_wdata;
                REG_DRIVE: drive_q <= reg_wdata;
                default:   ;
            endcase
        end
    end

    // Read data: output pins show latch, input pins show pad level
    always_comb begin
        case (reg_sel_e'(reg_addr))
            REG_DATA:  reg_rdata = (latch_q & dir_q) | (pin_lvl & ~dir_q);
            REG_DRIVE: reg_rdata = drive_q;
            default:   reg_rdata = RD_FIXED;
        endcase
    end

    // R1
    dir_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == REG_DIR) |=> dir_q == $past(reg_wdata));

    // R10
    drive_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> drive_q == ONES);

    // R3
    latch_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> latch_q == ONES);

    // R2
    wo_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == REG_DIR || reg_addr == REG_FUNC) |-> reg_rdata == RD_FIXED);
endmodule

// File: rtl/gpio_pinmux.sv
// Module: gpio_pinmux
// Per-pin selection of pad value and enable between port latch and
// alternate bus/NAND signals, with standby gating and input routing.
// Assumes pin positions fixed by gpio_pkg.
module gpio_pinmux
    import gpio_pkg::*;
#(
    parameter int unsigned W = N_PINS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         standby,
    input  logic [W-1:0] latch_q,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] func_q,
    input  logic [W-1:0] drive_q,
    input  logic         bus_rd_n,
    input  logic         bus_wr_lo_n,
    input  logic         bus_wr_hi_n,
    input  logic         bus_rw,
    input  logic [1:0]   bus_addr_hi,
    input  logic         nand_re_n,
    input  logic         nand_we_n,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pin_lvl,
    output logic         bus_wait_n,
    output logic         nand_ready
);
    logic [W-1:0] gate_off;

    // Standby gating: buffers without a drive bit are shut off
    assign gate_off = standby ? ~drive_q : '0;

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic raw_out;
        logic raw_oe;

        if (i == PIN_RD) begin : g_rd
            // Pin 0: read strobe overrides the port when selected
            always_comb begin
                raw_out = func_q[i] ? bus_rd_n : latch_q[i];
                raw_oe  = func_q[i] | dir_q[i];
            end
        end else if (i == PIN_RE || i == PIN_WE) begin : g_strobe
            logic nand_s;
            logic wr_s;
            assign nand_s = (i == PIN_RE) ? nand_re_n : nand_we_n;
            assign wr_s   = (i == PIN_RE) ? bus_wr_lo_n : bus_wr_hi_n;
            // Pins 1/2: latch bit picks NAND or byte-write strobe
            always_comb begin
                raw_oe = dir_q[i];
                if (func_q[i] && dir_q[i])
                    raw_out = latch_q[i] ? wr_s : nand_s;
                else
                    raw_out = latch_q[i];
            end
        end else if (i == PIN_A24 || i == PIN_A25) begin : g_addr
            // Pins 3/4: upper address bits when selected
            always_comb begin
                raw_out = func_q[i] ? bus_addr_hi[i - PIN_A24] : latch_q[i];
                raw_oe  = func_q[i] | dir_q[i];
            end
        end else if (i == PIN_RB) begin : g_rb
            // Pin 5: read/write indicator in output mode
            always_comb begin
                raw_out = (func_q[i] && dir_q[i]) ? bus_rw : latch_q[i];
                raw_oe  = dir_q[i];
            end
        end else begin : g_plain
            // Remaining pins: plain port behaviour
            always_comb begin
                raw_out = latch_q[i];
                raw_oe  = dir_q[i];
            end
        end

        assign pad_out[i] = raw_out;
        assign pad_oe[i]  = raw_oe & ~gate_off[i];
        assign pin_lvl[i] = gate_off[i] | pad_in[i];

        // R10
        standby_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (standby && !drive_q[i]) |-> (!pad_oe[i] && pin_lvl[i]));

        if (i == PIN_RE || i == PIN_WE) begin : g_chk
            // R6
            reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (func_q[i] && !dir_q[i]) |-> !pad_oe[i]);
            // R4
            strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (func_q[i] && dir_q[i] && !latch_q[i] && !gate_off[i]) |->
                (pad_oe[i] && pad_out[i] == ((i == PIN_RE) ? nand_re_n : nand_we_n)));
        end
    end

    // Input routing: unrouted inputs read as inactive high
    assign bus_wait_n = (func_q[PIN_WAIT] && !dir_q[PIN_WAIT]) ? pin_lvl[PIN_WAIT] : 1'b1;
    assign nand_ready = (func_q[PIN_RB] && !dir_q[PIN_RB]) ? pin_lvl[PIN_RB] : 1'b1;

    // R8
    wait_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !func_q[PIN_WAIT] |-> bus_wait_n);
endmodule

// File: rtl/gpio_mux_port.sv
// Module: gpio_mux_port (top)
// Eight-pin GPIO port with alternate bus and NAND strobe functions.
// Assumes the bus controller stub holds strobes high when idle.
module gpio_mux_port
    import gpio_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          boot_rd_func,
    input  logic          standby,
    input  logic [1:0]    reg_addr,
    input  logic          reg_wr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    input  logic          bus_rd_n,
    input  logic          bus_wr_lo_n,
    input  logic          bus_wr_hi_n,
    input  logic          bus_rw,
    input  logic [1:0]    bus_addr_hi,
    input  logic          nand_re_n,
    input  logic          nand_we_n,
    output logic          bus_wait_n,
    output logic          nand_ready,
    input  logic [7:0]    pad_in,
    output logic [7:0]    pad_out,
    output logic [7:0]    pad_oe
);
    logic [N_PINS-1:0] latch_q;
    logic [N_PINS-1:0] dir_q;
    logic [N_PINS-1:0] func_q;
    logic [N_PINS-1:0] drive_q;
    logic [N_PINS-1:0] pin_lvl;

    gpio_regs #(.W(N_PINS), .RD_FIXED('0)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .boot_rd_func (boot_rd_func),
        .reg_addr     (reg_addr),
        .reg_wr       (reg_wr),
        .reg_wdata    (reg_wdata),
        .pin_lvl      (pin_lvl),
        .reg_rdata    (reg_rdata),
        .latch_q      (latch_q),
        .dir_q        (dir_q),
        .func_q       (func_q),
        .drive_q      (drive_q)
    );

    gpio_pinmux #(.W(N_PINS)) u_mux (
        .clk          (clk),
        .rst_n        (rst_n),
        .standby      (standby),
        .latch_q      (latch_q),
        .dir_q        (dir_q),
        .func_q       (func_q),
        .drive_q      (drive_q),
        .bus_rd_n     (bus_rd_n),
        .bus_wr_lo_n  (bus_wr_lo_n),
        .bus_wr_hi_n  (bus_wr_hi_n),
        .bus_rw       (bus_rw),
        .bus_addr_hi  (bus_addr_hi),
        .nand_re_n    (nand_re_n),
        .nand_we_n    (nand_we_n),
        .pad_in       (pad_in),
        .pad_out      (pad_out),
        .pad_oe       (pad_oe),
        .pin_lvl      (pin_lvl),
        .bus_wait_n   (bus_wait_n),
        .nand_ready   (nand_ready)
    );

    // R9
    rd_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        func_q[PIN_RD] |-> (pad_out[PIN_RD] == bus_rd_n));

    // R7
    addr_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (func_q[PIN_A25] && !(standby && !drive_q[PIN_A25])) |->
        (pad_oe[PIN_A25] && pad_out[PIN_A25] == bus_addr_hi[1]));
endmodule

// File: tb/gpio_mux_port_bench.sv
// Directed bench for gpio_mux_port, one task per scenario.
module gpio_mux_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       boot_rd_func = 1'b0;
    logic       standby = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       bus_rd_n = 1'b1;
    logic       bus_wr_lo_n = 1'b1;
    logic       bus_wr_hi_n = 1'b1;
    logic       bus_rw = 1'b1;
    logic [1:0] bus_addr_hi = 2'b00;
    logic       nand_re_n = 1'b1;
    logic       nand_we_n = 1'b1;
    logic       bus_wait_n;
    logic       nand_ready;
    logic [7:0] pad_in = 8'h00;
    logic [7:0] pad_out;
    logic [7:0] pad_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_mux_port u_gpio_mux_port (
        .clk(clk), .rst_n(rst_n), .boot_rd_func(boot_rd_func), .standby(standby),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bus_rd_n(bus_rd_n), .bus_wr_lo_n(bus_wr_lo_n), .bus_wr_hi_n(bus_wr_hi_n),
        .bus_rw(bus_rw), .bus_addr_hi(bus_addr_hi), .nand_re_n(nand_re_n),
        .nand_we_n(nand_we_n), .bus_wait_n(bus_wait_n), .nand_ready(nand_ready),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset(logic mode);
        @(negedge clk);
        rst_n = 1'b0; boot_rd_func = mode; standby = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Write lands at next rising edge; result sampled on following falling edge
    task automatic wr(logic [1:0] a, logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic t_reset_state();
        logic [7:0] d;
        do_reset(1'b0);
        pad_in = 8'hA5;
        #1 check("R1 oe after reset", pad_oe, 8'h00);
        rd(2'd0, d); check("R3 inputs read pads", d, 8'hA5);
        rd(2'd1, d); check("R2 dir read fixed", d, 8'h00);
        rd(2'd2, d); check("R2 func read fixed", d, 8'h00);
        rd(2'd3, d); check("R10 drive reset", d, 8'hFF);
        wr(2'd1, 8'hFF);
        rd(2'd0, d); check("R3 latch reset ones", d, 8'hFF);
        check("R1 all outputs", pad_oe, 8'hFF);
        check("R1 out from latch", pad_out, 8'hFF);
    endtask

    task automatic t_plain_io();
        logic [7:0] d;
        do_reset(1'b0);
        wr(2'd1, 8'hF0); wr(2'd0, 8'h5A);
        pad_in = 8'h3C;
        rd(2'd0, d); check("R3 mixed readback", d, 8'h5C);
        check("R1 oe follows dir", pad_oe, 8'hF0);
        check("R1 out follows latch", pad_out & 8'hF0, 8'h50);
        wr(2'd2, 8'hA7);
        rd(2'd1, d); check("R2 dir stays hidden", d, 8'h00);
        rd(2'd2, d); check("R2 func stays hidden", d, 8'h00);
    endtask

    task automatic t_pin2();
        do_reset(1'b0);
        wr(2'd0, 8'hFB); wr(2'd2, 8'h04); wr(2'd1, 8'h04);
        nand_we_n = 1'b0; #1;
        check("R4 we strobe low", {7'd0, pad_out[2]}, 8'h00);
        check("R4 oe", {7'd0, pad_oe[2]}, 8'h01);
        nand_we_n = 1'b1; bus_wr_hi_n = 1'b0; #1;
        check("R4 we strobe high", {7'd0, pad_out[2]}, 8'h01);
        @(negedge clk); bus_wr_hi_n = 1'b1;
        wr(2'd0, 8'hFF);
        bus_wr_hi_n = 1'b0; #1;
        check("R4 wr_hi low", {7'd0, pad_out[2]}, 8'h00);
        nand_we_n = 1'b0; bus_wr_hi_n = 1'b1; #1;
        check("R4 nand ignored", {7'd0, pad_out[2]}, 8'h01);
        nand_we_n = 1'b1;
    endtask

    task automatic t_pin1();
        do_reset(1'b0);
        wr(2'd0, 8'hFD); wr(2'd2, 8'h02); wr(2'd1, 8'h02);
        nand_re_n = 1'b0; #1;
        check("R5 re strobe", {6'd0, pad_oe[1], pad_out[1]}, 8'h02);
        nand_re_n = 1'b1;
        @(negedge clk);
        wr(2'd0, 8'hFF);
        bus_wr_lo_n = 1'b0; #1;
        check("R5 wr_lo strobe", {6'd0, pad_oe[1], pad_out[1]}, 8'h02);
        bus_wr_lo_n = 1'b1;
    endtask

    task automatic t_reserved();
        logic [7:0] d;
        do_reset(1'b0);
        wr(2'd2, 8'h06);
        pad_in = 8'h04;
        nand_re_n = 1'b0; nand_we_n = 1'b0;
        rd(2'd0, d);
        check("R6 reserved oe", pad_oe & 8'h06, 8'h00);
        check("R6 reserved read pads", d & 8'h06, 8'h04);
        nand_re_n = 1'b1; nand_we_n = 1'b1;
    endtask

    task automatic t_addr();
        do_reset(1'b0);
        wr(2'd0, 8'h00);
        bus_addr_hi = 2'b10; #1;
        check("R7 port mode inputs", pad_oe & 8'h18, 8'h00);
        @(negedge clk);
        wr(2'd2, 8'h18); #1;
        check("R7 addr oe", pad_oe & 8'h18, 8'h18);
        check("R7 addr value", pad_out & 8'h18, 8'h10);
        bus_addr_hi = 2'b01; #1;
        check("R7 addr follows", pad_out & 8'h18, 8'h08);
        bus_addr_hi = 2'b00;
    endtask

    task automatic t_routes();
        do_reset(1'b0);
        pad_in = 8'h00; #1;
        check("R8 unrouted high", {6'd0, bus_wait_n, nand_ready}, 8'h03);
        @(negedge clk);
        wr(2'd2, 8'h60); #1;
        check("R8 routed low", {6'd0, bus_wait_n, nand_ready}, 8'h00);
        pad_in = 8'h40; #1;
        check("R8 wait follows pad", {6'd0, bus_wait_n, nand_ready}, 8'h02);
        @(negedge clk);
        wr(2'd1, 8'h20);
        bus_rw = 1'b0; #1;
        check("R8 rw driven", {6'd0, pad_oe[5], pad_out[5]}, 8'h02);
        check("R8 rb unrouted", {7'd0, nand_ready}, 8'h01);
        bus_rw = 1'b1; #1;
        check("R8 rw high", {7'd0, pad_out[5]}, 8'h01);
    endtask

    task automatic t_pin0();
        do_reset(1'b1);
        bus_rd_n = 1'b0; #1;
        check("R9 boot rd on", {6'd0, pad_oe[0], pad_out[0]}, 8'h02);
        bus_rd_n = 1'b1; #1;
        check("R9 rd follows", {7'd0, pad_out[0]}, 8'h01);
        @(negedge clk);
        wr(2'd2, 8'h00); #1;
        check("R9 rd released", {7'd0, pad_oe[0]}, 8'h00);
        do_reset(1'b0); #1;
        check("R9 boot rd off", {7'd0, pad_oe[0]}, 8'h00);
    endtask

    task automatic t_standby();
        logic [7:0] d;
        do_reset(1'b0);
        wr(2'd3, 8'h7F);
        pad_in = 8'h00;
        standby = 1'b1;
        rd(2'd0, d); check("R10 forced input", d, 8'h80);
        rd(2'd3, d); check("R10 drive readback", d, 8'h7F);
        @(negedge clk);
        wr(2'd1, 8'hFF); #1;
        check("R10 oe gated", pad_oe, 8'h7F);
        standby = 1'b0; #1;
        check("R10 no gate awake", pad_oe, 8'hFF);
    endtask

    function automatic logic pin_lvl_eff(int i);
        return pad_oe[i] ? pad_out[i] : 1'b1;
    endfunction

    task automatic t_order();
        do_reset(1'b0);
        wr(2'd0, 8'hF9); #1;
        check("R11 after latch", {6'd0, pin_lvl_eff(2), pin_lvl_eff(1)}, 8'h03);
        @(negedge clk);
        wr(2'd2, 8'h06); #1;
        check("R11 after func", {6'd0, pin_lvl_eff(2), pin_lvl_eff(1)}, 8'h03);
        @(negedge clk);
        wr(2'd1, 8'h06); #1;
        check("R11 after dir", {6'd0, pin_lvl_eff(2), pin_lvl_eff(1)}, 8'h03);
        check("R11 strobes driven", pad_oe & 8'h06, 8'h06);
    endtask

    initial begin
        t_reset_state();
        t_plain_io();
        t_pin2();
        t_pin1();
        t_reserved();
        t_addr();
        t_routes();
        t_pin0();
        t_standby();
        t_order();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule